// File: doc/BRIEF.md
# Privileged Countdown Interval Timer

This block is a down-counting interval timer that lets supervisor software take the processor back after a programmed number of ticks. Only the supervisor can program it. A reload presented while the core runs in supervisor mode copies a new value into the counter. A reload presented in user mode is refused and reported on a one-cycle fault output. Each tick-enable pulse lowers the counter by one. When the counter reaches zero, an interrupt request goes high and stays high until it is acknowledged or a new value is loaded.

A separate free-running counter advances on every tick, whatever the interval timer is doing. Software uses it to keep time. After reset the interval counter sits at zero and does not count until the first privileged load.

Top module: `priv_interval_timer`

## Requirements
- R1: After reset, count, irq, priv_fault and time_ticks are all 0, and ticks leave count at 0 and irq low until the first accepted load.
- R2: A load request with mode_user = 0 (supervisor) puts load_val on count in the next cycle and clears irq.
- R3: A load request with mode_user = 1 (user) does not change count. count holds, or drops by one if a tick is present in that cycle.
- R4: priv_fault is high in exactly the cycle after each cycle with load_req = 1 and mode_user = 1. Otherwise it is low.
- R5: A tick with a nonzero count and no accepted load lowers count by exactly one in the next cycle.
- R6: irq rises in the cycle after count steps from 1 to 0. Once at 0, count stays at 0 until the next accepted load.
- R7: Once raised, irq stays high until irq_ack is seen or an accepted load occurs. irq falls in the cycle after either one.
- R8: When an accepted load and a tick fall in the same cycle, the load wins and count equals load_val with no decrement.
- R9: time_ticks rises by one on every tick_en and wraps to 0 after 2^TIME_W - 1.
- R10: An accepted load of 0 leaves count at 0 with irq low, so the timer stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Single-cycle tick pulse |
| mode_user | input | 1 | Current mode: 0 supervisor, 1 user |
| load_req | input | 1 | Request to reload the interval counter |
| load_val | input | CNT_W | Value to load |
| irq_ack | input | 1 | Acknowledge of the interrupt request |
| irq | output | 1 | Interrupt request, level |
| count | output | CNT_W | Current interval count |
| priv_fault | output | 1 | One-cycle flag for a refused user-mode load |
| time_ticks | output | TIME_W | Free-running tick count |

## Verification
Every load value from 0 to 24 is programmed in supervisor mode. For each one, the bench runs ticks until expiry and then for a few more ticks. This separates off-by-one expiry timing from correct timing, and shows whether the counter really holds at zero. Some loads arrive together with a tick, which shows whether a load overrides a decrement. User-mode loads are tried with the tick on and off and at nonzero counts, so a refused load cannot be confused with a decrement. Ack placement and the 6-bit timekeeping wrap are exercised as separate patterns. Every cycle is compared against an arithmetic model kept in the bench.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic {
    MODE_SUPER = 1'b0,
    MODE_USER  = 1'b1
  } cpu_mode_e;
endpackage

// File: rtl/pit_load_gate.sv
module pit_load_gate
  import pit_pkg::*;
(
  input  logic load_req,
  input  logic mode_user,
  output logic load_ok,
  output logic load_bad
);
  cpu_mode_e mode;
  assign mode     = cpu_mode_e'(mode_user);
  assign load_ok  = load_req && (mode == MODE_SUPER);
  assign load_bad = load_req && (mode == MODE_USER);
endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load_ok,
  input  logic [CNT_W-1:0] load_val,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             expire_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - ONE;
  endfunction

  logic dec_evt;
  assign dec_evt    = tick_en && !load_ok && (count != '0);
  assign expire_evt = dec_evt && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      if (load_ok)      count <= load_val;
      else if (dec_evt) count <= step_down(count);

      if (load_ok)         irq <= 1'b0;
      else if (expire_evt) irq <= 1'b1;
      else if (irq_ack)    irq <= 1'b0;
    end
  end
endmodule

// File: rtl/pit_tick_clock.sv
module pit_tick_clock #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  output logic [TIME_W-1:0] time_ticks
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_ticks <= '0;
    else if (tick_en) time_ticks <= time_ticks + TIME_W'(1);
  end
endmodule

// File: rtl/priv_interval_timer.sv
module priv_interval_timer #(
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              mode_user,
  input  logic              load_req,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              irq_ack,
  output logic              irq,
  output logic [CNT_W-1:0]  count,
  output logic              priv_fault,
  output logic [TIME_W-1:0] time_ticks
);
  logic load_ok;
  logic load_bad;
  logic expire_evt;

  pit_load_gate u_gate (
    .load_req (load_req),
    .mode_user(mode_user),
    .load_ok  (load_ok),
    .load_bad (load_bad)
  );

  pit_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .load_ok   (load_ok),
    .load_val  (load_val),
    .irq_ack   (irq_ack),
    .count     (count),
    .irq       (irq),
    .expire_evt(expire_evt)
  );

  pit_tick_clock #(.TIME_W(TIME_W)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .time_ticks(time_ticks)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) priv_fault <= 1'b0;
    else        priv_fault <= load_bad;
  end
endmodule

// File: rtl/pit_chk.sv
module pit_chk #(
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              load_req,
  input logic              mode_user,
  input logic [CNT_W-1:0]  load_val,
  input logic              irq_ack,
  input logic              irq,
  input logic [CNT_W-1:0]  count,
  input logic              priv_fault,
  input logic [TIME_W-1:0] time_ticks,
  input logic              load_ok,
  input logic              expire_evt
);
  // R2
  super_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !mode_user) |=> (count == $past(load_val) && !irq));
  // R3
  user_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && mode_user && !tick_en) |=> $stable(count));
  // R4
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && mode_user) |=> priv_fault);
  // R4
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_req && mode_user) |=> !priv_fault);
  // R5
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load_ok && count != '0) |=> (count == $past(count) - CNT_W'(1)));
  // R6
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load_ok) |=> (count == '0));
  // R6
  expire_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (irq && count == '0));
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack && !load_ok) |=> irq);
  // R9
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (time_ticks == $past(time_ticks) + TIME_W'(1)));
endmodule

bind priv_interval_timer pit_chk #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_req(load_req),
  .mode_user(mode_user), .load_val(load_val), .irq_ack(irq_ack), .irq(irq),
  .count(count), .priv_fault(priv_fault), .time_ticks(time_ticks),
  .load_ok(load_ok), .expire_evt(expire_evt)
);

// File: tb/priv_interval_timer_tb.sv
module priv_interval_timer_tb;
  localparam int PERIOD = 10;
  localparam int CW = 8;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, mode_user = 1'b0, load_req = 1'b0, irq_ack = 1'b0;
  logic [CW-1:0] load_val = '0;
  logic irq, priv_fault;
  logic [CW-1:0] count;
  logic [TW-1:0] time_ticks;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [CW-1:0] m_cnt = '0;
  logic m_irq = 1'b0, m_fault = 1'b0;
  logic [TW-1:0] m_time = '0;

  always #(PERIOD/2) clk = ~clk;

  priv_interval_timer #(.CNT_W(CW), .TIME_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_user(mode_user),
    .load_req(load_req), .load_val(load_val), .irq_ack(irq_ack),
    .irq(irq), .count(count), .priv_fault(priv_fault), .time_ticks(time_ticks)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "count", int'(count), int'(m_cnt));
    check(tag, "irq", int'(irq), int'(m_irq));
    check(tag, "priv_fault", int'(priv_fault), int'(m_fault));
    check(tag, "time_ticks", int'(time_ticks), int'(m_time));
  endtask

  // one clock: apply inputs, advance the arithmetic model, compare
  task automatic step(input logic tk, input logic ld, input logic usr,
                      input logic [CW-1:0] v, input logic ack, input string tag);
    logic accepted;
    @(negedge clk);
    tick_en = tk; load_req = ld; mode_user = usr; load_val = v; irq_ack = ack;
    @(posedge clk);
    accepted = ld && !usr;
    m_fault = ld && usr;
    if (tk) m_time = m_time + 1'b1;
    if (accepted) begin
      m_cnt = v; m_irq = 1'b0;
    end else if (tk && m_cnt != 0) begin
      m_cnt = m_cnt - 1'b1;
      if (m_cnt == 0) m_irq = 1'b1;
      else if (ack) m_irq = 1'b0;
    end else if (ack) m_irq = 1'b0;
    #2;
    check_all(tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_all("R1");
    // R1: ticks before any load leave the timer idle
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, '0, 1'b0, "R1");

    // R5 R6 R8: sweep load values; odd ones loaded together with a tick
    for (int v = 0; v < 25; v++) begin
      step(v[0], 1'b1, 1'b0, CW'(v), 1'b0, "R8");
      if (v[0]) check("R8", "count after load+tick", int'(count), v);
      for (int t = 0; t < v + 3; t++) begin
        step(1'b1, 1'b0, 1'b0, '0, 1'b0, (t < v) ? "R5" : "R6");
        step(1'b0, 1'b0, 1'b0, '0, 1'b0, "R6");
      end
      // R7: irq held until acknowledged
      step(1'b0, 1'b0, 1'b0, '0, 1'b0, "R7");
      step(1'b0, 1'b0, 1'b0, '0, 1'b1, "R7");
      check("R7", "irq after ack", int'(irq), 0);
    end

    // R3 R4: user-mode loads at nonzero count, with and without tick
    step(1'b0, 1'b1, 1'b0, CW'(40), 1'b0, "R2");
    for (int i = 0; i < 6; i++) begin
      step(i[0], 1'b1, 1'b1, CW'(200), 1'b0, "R3");
      check("R4", "priv_fault", int'(priv_fault), 1);
      step(1'b0, 1'b0, 1'b1, CW'(200), 1'b0, "R4");
      check("R4", "priv_fault quiet", int'(priv_fault), 0);
    end

    // R2: supervisor reload clears a pending irq
    step(1'b0, 1'b1, 1'b0, CW'(1), 1'b0, "R2");
    step(1'b1, 1'b0, 1'b0, '0, 1'b0, "R6");
    check("R6", "irq at expiry", int'(irq), 1);
    step(1'b0, 1'b1, 1'b0, CW'(9), 1'b0, "R2");
    check("R2", "irq cleared by load", int'(irq), 0);

    // R10: loading zero idles the timer
    step(1'b0, 1'b1, 1'b0, '0, 1'b0, "R10");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, '0, 1'b0, "R10");
    check("R10", "irq after zero load", int'(irq), 0);

    // R9: run the tick clock through a wrap
    for (int i = 0; i < 70; i++) step(1'b1, 1'b0, i[1], '0, 1'b0, "R9");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule